// File: doc/BRIEF.md
# Serial-Loaded Bank Controller

This block maps banks of a cartridge's program ROM and pattern ROM for an 8-bit CPU. The CPU sets it up by writing into the ROM address range. Each write carries one configuration bit. Five of these writes fill a 5-bit staging value. The fifth write copies that value into one of four registers, and the address of that fifth write picks which one. The four registers are a mode register, two pattern bank registers and a program bank register. A write with data bit 7 set abandons a sequence that is only partly entered.

From the mode register and the bank registers, the block turns the current CPU and video addresses into the upper ROM address bits. It also reports the nametable mirroring arrangement. While the CPU writes into the ROM range, the block holds the program ROM output enable low, so the ROM does not drive the data bus at the same time as the CPU.

Top module: `serial_bank_ctrl`

## Requirements
- R1: Only data bit 0 of a write with address bit 15 high is used. Bits are collected least significant first, so the first of the five writes becomes bit 0 of the loaded value.
- R2: The fifth collected write commits the value. Address bits 14:13 of that fifth write alone pick the target: 00 is the mode register, 01 is pattern bank A, 10 is pattern bank B and 11 is the program bank. The addresses of the first four writes do not matter.
- R3: Before the fifth write, no register and no output mapping changes.
- R4: A write with data bit 7 set clears the partial sequence and shifts in nothing, whatever data bit 0 is. It also sets mode bits 3 and 2 to 1.
- R5: After reset, the mode register is 5'b01100 and all bank registers are 0.
- R6: `mirror_o` is 0 for vertical, 1 for horizontal, 2 for single-screen page 0 and 3 for single-screen page 1. Mode bit 1 = 1 gives normal mirroring, with mode bit 0 choosing 0 = vertical or 1 = horizontal. Mode bit 1 = 0 gives single-screen, with mode bit 0 choosing the page.
- R7: With mode bit 3 = 0 (32 KB switching), `prg_bank_o` is {program bank bits 3:1, CPU A14}.
- R8: With mode bit 3 = 1 (16 KB switching), one 16 KB window is switched to program bank bits 3:0 and the other is fixed. Mode bit 2 = 1 switches A14 = 0 and fixes A14 = 1 to bank 15. Mode bit 2 = 0 switches A14 = 1 and fixes A14 = 0 to bank 0.
- R9: With mode bit 4 = 0, `chr_bank_o` is {pattern bank A bits 4:1, video A12}, and pattern bank B has no effect.
- R10: With mode bit 4 = 1, `chr_bank_o` is pattern bank A when video A12 = 0 and pattern bank B when video A12 = 1.
- R11: `prg_oe_o` is high exactly when CPU A15 is high and no write is in progress.
- R12: Writes with A15 low change neither the sequence nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one CPU write is sampled per cycle with `cpu_wr_i` high |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| cpu_a_i | input | 3 | CPU address bits 15:13 |
| cpu_d7_i | input | 1 | CPU data bit 7 (sequence clear) |
| cpu_d0_i | input | 1 | CPU data bit 0 (serial bit) |
| ppu_a12_i | input | 1 | Video address bit 12 |
| prg_bank_o | output | 4 | Program ROM address bits 17:14 |
| chr_bank_o | output | 5 | Pattern ROM address bits 16:12 |
| mirror_o | output | 2 | Nametable mirroring code (R6) |
| prg_oe_o | output | 1 | Program ROM output enable, active high |

## Verification
The bench aims at the commit point. A design that commits on the fourth write, or that uses the address of the first write instead of the fifth, would load the wrong register or a shifted value. A clear entered mid-sequence with data bit 0 set must leave no stray bit behind; a design that shifts on the clear would be off by one for every later load. All 32 mode values are swept while both CPU A14 and video A12 toggle. This exposes a swapped fixed bank, a failure to drop bit 0 in 32 KB mode, or pattern bank B leaking into 8 KB mode. Writes with A15 low are interleaved into sequences, so a design that counts them would commit early.

// File: rtl/serial_bank_pkg.sv
package serial_bank_pkg;
  localparam int unsigned SHIFT_W = 5;
  localparam int unsigned CNT_W   = $clog2(SHIFT_W);

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    WIN_MODE = 2'd0,
    WIN_CHRA = 2'd1,
    WIN_CHRB = 2'd2,
    WIN_PRG  = 2'd3
  } win_e;

  typedef struct packed {
    logic chr_4k;
    logic prg_16k;
    logic prg_sw_low;  // 1: switched window is A14=0
    logic mir_normal;
    logic mir_sel;
  } mode_t;

  localparam logic [SHIFT_W-1:0] MODE_RST = 5'b01100;
endpackage

// File: rtl/sbc_shift_loader.sv
module sbc_shift_loader
  import serial_bank_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,     // qualified ROM-range write
  input  logic               clr_i,
  input  logic               bit_i,
  output logic               commit_o,
  output logic [SHIFT_W-1:0] value_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [SHIFT_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               last_w;

  assign last_w   = (cnt_q == CNT_W'(SHIFT_W - 1));
  assign commit_o = wr_i && !clr_i && last_w;
  assign value_o  = {bit_i, sr_q[SHIFT_W-1:1]};
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (wr_i) begin
      if (clr_i || last_w) begin
        sr_q  <= '0;
        cnt_q <= '0;
      end else begin
        sr_q  <= {bit_i, sr_q[SHIFT_W-1:1]};
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sbc_reg_file.sv
module sbc_reg_file
  import serial_bank_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  commit_i,
  input  logic                  clr_i,
  input  win_e                  win_i,
  input  logic [SHIFT_W-1:0]    value_i,
  output logic [SHIFT_W-1:0]    mode_o,
  output logic [SHIFT_W-1:0]    chr_a_o,
  output logic [SHIFT_W-1:0]    chr_b_o,
  output logic [PRG_BANK_W-1:0] prg_o
);
  logic [SHIFT_W-1:0]    mode_q, chr_a_q, chr_b_q;
  logic [PRG_BANK_W-1:0] prg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RST;
      chr_a_q <= '0;
      chr_b_q <= '0;
      prg_q   <= '0;
    end else if (clr_i) begin
      mode_q <= mode_q | MODE_RST;
    end else if (commit_i) begin
      unique case (win_i)
        WIN_MODE: mode_q  <= value_i;
        WIN_CHRA: chr_a_q <= value_i;
        WIN_CHRB: chr_b_q <= value_i;
        WIN_PRG:  prg_q   <= value_i[PRG_BANK_W-1:0];
        default:  ;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign chr_a_o = chr_a_q;
  assign chr_b_o = chr_b_q;
  assign prg_o   = prg_q;
endmodule

// File: rtl/sbc_prg_map.sv
module sbc_prg_map
  import serial_bank_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 4
) (
  input  mode_t                 mode_i,
  input  logic [PRG_BANK_W-1:0] bank_i,
  input  logic                  a14_i,
  output logic [PRG_BANK_W-1:0] bank_o
);
  localparam logic [PRG_BANK_W-1:0] LAST = '1;

  always_comb begin
    if (!mode_i.prg_16k) begin
      bank_o = {bank_i[PRG_BANK_W-1:1], a14_i};
    end else if (mode_i.prg_sw_low) begin
      bank_o = a14_i ? LAST : bank_i;
    end else begin
      bank_o = a14_i ? bank_i : '0;
    end
  end
endmodule

// File: rtl/sbc_chr_map.sv
module sbc_chr_map
  import serial_bank_pkg::*;
(
  input  logic               chr_4k_i,
  input  logic [SHIFT_W-1:0] bank_a_i,
  input  logic [SHIFT_W-1:0] bank_b_i,
  input  logic               a12_i,
  output logic [SHIFT_W-1:0] bank_o
);
  always_comb begin
    if (chr_4k_i) bank_o = a12_i ? bank_b_i : bank_a_i;
    else          bank_o = {bank_a_i[SHIFT_W-1:1], a12_i};
  end
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
  import serial_bank_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_wr_i,
  input  logic [2:0]            cpu_a_i,
  input  logic                  cpu_d7_i,
  input  logic                  cpu_d0_i,
  input  logic                  ppu_a12_i,
  output logic [PRG_BANK_W-1:0] prg_bank_o,
  output logic [SHIFT_W-1:0]    chr_bank_o,
  output logic [1:0]            mirror_o,
  output logic                  prg_oe_o
);
  logic                  rom_wr_w, clr_w, commit_w;
  logic [SHIFT_W-1:0]    value_w, mode_q, chr_a_w, chr_b_w;
  logic [PRG_BANK_W-1:0] prg_w;
  logic [CNT_W-1:0]      cnt_q;
  mode_t                 mode_s;

  assign rom_wr_w = cpu_wr_i && cpu_a_i[2];
  assign clr_w    = rom_wr_w && cpu_d7_i;
  assign mode_s   = mode_t'(mode_q);

  sbc_shift_loader i_loader (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (rom_wr_w),
    .clr_i    (cpu_d7_i),
    .bit_i    (cpu_d0_i),
    .commit_o (commit_w),
    .value_o  (value_w),
    .cnt_o    (cnt_q)
  );

  sbc_reg_file #(.PRG_BANK_W(PRG_BANK_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit_w),
    .clr_i    (clr_w),
    .win_i    (win_e'(cpu_a_i[1:0])),
    .value_i  (value_w),
    .mode_o   (mode_q),
    .chr_a_o  (chr_a_w),
    .chr_b_o  (chr_b_w),
    .prg_o    (prg_w)
  );

  sbc_prg_map #(.PRG_BANK_W(PRG_BANK_W)) i_prg_map (
    .mode_i (mode_s),
    .bank_i (prg_w),
    .a14_i  (cpu_a_i[1]),
    .bank_o (prg_bank_o)
  );

  sbc_chr_map i_chr_map (
    .chr_4k_i (mode_s.chr_4k),
    .bank_a_i (chr_a_w),
    .bank_b_i (chr_b_w),
    .a12_i    (ppu_a12_i),
    .bank_o   (chr_bank_o)
  );

  always_comb begin
    unique case ({mode_s.mir_normal, mode_s.mir_sel})
      2'b10:   mirror_o = MIR_VERT;
      2'b11:   mirror_o = MIR_HORZ;
      2'b00:   mirror_o = MIR_ONE_LO;
      default: mirror_o = MIR_ONE_HI;
    endcase
  end

  assign prg_oe_o = cpu_a_i[2] && !cpu_wr_i;
endmodule

// File: rtl/serial_bank_ctrl_chk.sv
module serial_bank_ctrl_chk
  import serial_bank_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cpu_wr_i,
  input logic [2:0]            cpu_a_i,
  input logic                  cpu_d7_i,
  input logic                  ppu_a12_i,
  input logic [PRG_BANK_W-1:0] prg_bank_o,
  input logic [SHIFT_W-1:0]    chr_bank_o,
  input logic [1:0]            mirror_o,
  input logic                  prg_oe_o,
  input logic [SHIFT_W-1:0]    mode_q,
  input logic [CNT_W-1:0]      cnt_q
);
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(SHIFT_W));

  p_commit_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_a_i[2] && cnt_q == CNT_W'(SHIFT_W - 1)) |=> cnt_q == '0);

  p_mode_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_wr_i && cpu_a_i[2]) |=> $stable(mode_q));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_a_i[2] && cpu_d7_i) |=> (cnt_q == '0 && mode_q[3:2] == 2'b11));

  p_single_screen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[1] |-> mirror_o[1]);

  p_32k_low_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[3] |-> prg_bank_o[0] == cpu_a_i[1]);

  p_8k_low_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[4] |-> chr_bank_o[0] == ppu_a12_i);

  p_oe_off_on_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_a_i[2]) |-> !prg_oe_o);

  p_low_write_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_a_i[2]) |=> ($stable(cnt_q) && $stable(mode_q)));
endmodule

bind serial_bank_ctrl serial_bank_ctrl_chk #(.PRG_BANK_W(PRG_BANK_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_wr_i   (cpu_wr_i),
  .cpu_a_i    (cpu_a_i),
  .cpu_d7_i   (cpu_d7_i),
  .ppu_a12_i  (ppu_a12_i),
  .prg_bank_o (prg_bank_o),
  .chr_bank_o (chr_bank_o),
  .mirror_o   (mirror_o),
  .prg_oe_o   (prg_oe_o),
  .mode_q     (mode_q),
  .cnt_q      (cnt_q)
);

// File: tb/test_serial_bank_ctrl.sv
`timescale 1ns/1ps
module test_serial_bank_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] a = 3'd0;
  logic       d7 = 1'b0;
  logic       d0 = 1'b0;
  logic       a12 = 1'b0;
  logic [3:0] prg_bank;
  logic [4:0] chr_bank;
  logic [1:0] mirror;
  logic       prg_oe;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R5";
  bit done = 1'b0;

  // behavioural model state
  int m_bits, m_n, m_mode, m_ca, m_cb, m_prg;

  always #2.5 clk = ~clk;

  serial_bank_ctrl i_serial_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(wr), .cpu_a_i(a),
    .cpu_d7_i(d7), .cpu_d0_i(d0), .ppu_a12_i(a12),
    .prg_bank_o(prg_bank), .chr_bank_o(chr_bank), .mirror_o(mirror), .prg_oe_o(prg_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bits = 0; m_n = 0; m_mode = 12; m_ca = 0; m_cb = 0; m_prg = 0;
    end else if (wr && a[2]) begin
      if (d7) begin
        m_bits = 0; m_n = 0; m_mode = m_mode | 12;
      end else begin
        if (d0) m_bits = m_bits + (1 << m_n);
        m_n = m_n + 1;
        if (m_n == 5) begin
          case (a[1:0])
            2'd0: m_mode = m_bits;
            2'd1: m_ca = m_bits;
            2'd2: m_cb = m_bits;
            default: m_prg = m_bits % 16;
          endcase
          m_bits = 0; m_n = 0;
        end
      end
    end
  end

  function automatic int exp_prg();
    int hi = a[1];
    if ((m_mode & 8) == 0) return (m_prg / 2) * 2 + hi;
    if ((m_mode & 4) != 0) return hi ? 15 : m_prg;
    return hi ? m_prg : 0;
  endfunction

  function automatic int exp_chr();
    if ((m_mode & 16) != 0) return a12 ? m_cb : m_ca;
    return (m_ca / 2) * 2 + int'(a12);
  endfunction

  function automatic int exp_mir();
    if ((m_mode & 2) != 0) return m_mode & 1;
    return 2 + (m_mode & 1);
  endfunction

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      cmp("prg_bank", int'(prg_bank), exp_prg());
      cmp("chr_bank", int'(chr_bank), exp_chr());
      cmp("mirror", int'(mirror), exp_mir());
      cmp("prg_oe R11", int'(prg_oe), (a[2] && !wr) ? 1 : 0);
    end
  end

  task automatic cyc(bit w, logic [2:0] ad, bit b7, bit b0);
    @(negedge clk);
    wr = w; a = ad; d7 = b7; d0 = b0; a12 = ~a12;
  endtask

  task automatic put(logic [2:0] ad, bit b7, bit b0);
    cyc(1'b1, ad, b7, b0);
    cyc(1'b0, ad, 1'b0, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'(i), 1'b0, 1'b0);
  endtask

  task automatic load(logic [1:0] win, int v);
    for (int i = 0; i < 5; i++) put({1'b1, win}, 1'b0, bit'((v >> i) & 1));
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    cur_req = "R5";
    idle(6);
    @(negedge clk); rst_n = 1'b1;
    idle(8);

    cur_req = "R4";  // clear after reset, bit 0 set on the clear write
    put(3'b100, 1'b1, 1'b1);
    idle(4);

    cur_req = "R1";
    load(2'd0, 5'b10110);
    idle(8);

    cur_req = "R6";
    for (int v = 0; v < 32; v++) begin
      cur_req = (v % 3 == 0) ? "R7" : (v % 3 == 1) ? "R8" : "R6";
      load(2'd0, v);
      idle(8);
    end

    cur_req = "R8";
    load(2'd3, 9);
    load(2'd0, 5'b01111); idle(8);
    load(2'd0, 5'b01011); idle(8);
    cur_req = "R7";
    load(2'd0, 5'b00011); idle(8);

    cur_req = "R9";
    load(2'd1, 5'b10111);
    load(2'd2, 5'b01010);
    load(2'd0, 5'b01100); idle(8);
    cur_req = "R10";
    load(2'd0, 5'b11100); idle(8);
    load(2'd2, 5'b00101); idle(8);

    cur_req = "R2";  // first four writes aimed elsewhere, fifth picks program bank
    put(3'b100, 1'b0, 1'b0);
    put(3'b101, 1'b0, 1'b1);
    put(3'b110, 1'b0, 1'b1);
    put(3'b100, 1'b0, 1'b0);
    put(3'b111, 1'b0, 1'b1);
    idle(8);

    cur_req = "R3";  // partial sequences must not disturb outputs
    put(3'b101, 1'b0, 1'b1); idle(6);
    put(3'b101, 1'b0, 1'b1); idle(6);
    put(3'b101, 1'b0, 1'b0); idle(6);
    put(3'b101, 1'b0, 1'b1); idle(6);
    cur_req = "R4";
    load(2'd0, 5'b10011); idle(4);
    put(3'b110, 1'b1, 1'b1); idle(6);
    load(2'd2, 5'b11001); idle(8);

    cur_req = "R12";
    put(3'b101, 1'b0, 1'b1);
    put(3'b001, 1'b0, 1'b0);
    put(3'b010, 1'b1, 1'b1);
    put(3'b101, 1'b0, 1'b1);
    put(3'b011, 1'b0, 1'b1);
    put(3'b101, 1'b0, 1'b0);
    put(3'b101, 1'b0, 1'b1);
    put(3'b101, 1'b0, 1'b1);
    idle(8);

    cur_req = "R11";
    for (int i = 0; i < 8; i++) cyc(1'b1, 3'(i), 1'b1, 1'b0);
    idle(8);
    summary();
  end
endmodule